// File: doc/BRIEF.md
# Context-Tagged Translation Lookaside Buffer

This block is a small, fully associative translation cache. Each slot holds one mapping from a virtual page number to a physical frame number, with permission bits, the address-space context that was current when the mapping was filled, and a global flag. A lookup presents a page number. One clock later the block returns hit, frame and permissions. The search compares the page number against every stored tag at the same time. A non-global slot hits only while its stored context equals the current context. A global slot hits in any context.

The current context comes from the low four bits of a root-table base word, which software writes when it switches address spaces. Those bits carry no address information, because the root table is page aligned. When the top bit of that word is clear, the write discards every non-global mapping. When the top bit is set, all mappings are kept so that a recently used context can resume with warm entries. A separate flush-all input clears everything, including global slots. After a miss, the page walker installs the mapping through the fill port. The fill reuses a slot that already holds the same page, or else takes the slot under a round-robin pointer.

Top module: `ctx_tlb`

## Requirements
- R1: A lookup request (`lk_valid`=1) at clock edge N produces `rsp_valid`=1 after edge N. On a hit, `rsp_pfn` and `rsp_perm` carry the stored frame and permissions. With no request at edge N, `rsp_valid` and `rsp_hit` are 0 after edge N.
- R2: A miss is reported as `rsp_hit`=0, with `rsp_pfn`=0 and `rsp_perm`=0.
- R3: A fill tags the slot with the current context. A non-global slot hits only while the current context equals that tag. The current context is `root_data[3:0]` of the last root write, and it is 0 after reset.
- R4: A slot filled with `fill_global`=1 hits on its page in every context.
- R5: A root write with `root_data[31]`=0 invalidates every non-global slot.
- R6: A root write with `root_data[31]`=1 keeps every slot valid and changes only the context.
- R7: Global slots survive a root write with `root_data[31]`=0.
- R8: `flush_all` invalidates every slot, global slots included.
- R9: A fill whose page matches a valid slot overwrites that slot rather than adding a second copy. A slot matches when the page is equal and its context equals the current one, or when either the slot or the fill is global. Any further matching slots are invalidated, and a later lookup returns the new frame.
- R10: A fill with no matching slot writes the slot under the round-robin pointer, which then advances and wraps after the last slot. The pointer is 0 after reset. After a full flush and ENTRIES distinct new fills, the next new fill evicts the first of them.
- R11: After reset no slot is valid and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Page number to translate |
| rsp_valid | output | 1 | Response of the lookup made on the previous edge |
| rsp_hit | output | 1 | Translation found |
| rsp_pfn | output | PFN_W | Frame number, 0 on miss |
| rsp_perm | output | PERM_W | Permission bits, 0 on miss |
| fill_valid | input | 1 | Install a mapping |
| fill_vpn | input | VPN_W | Page number of the new mapping |
| fill_pfn | input | PFN_W | Frame number of the new mapping |
| fill_perm | input | PERM_W | Permission bits of the new mapping |
| fill_global | input | 1 | Mark the new mapping global |
| root_wr | input | 1 | Load a new root-table base word |
| root_data | input | ROOT_W | Base word: low CTX_W bits are the context, top bit keeps entries |
| flush_all | input | 1 | Invalidate every slot |

## Verification
The assertions assume that a fill is never presented in the same cycle as a root write or a full flush. They also assume that a root write never coincides with a full flush. Under those conditions the invalidation and hold properties describe the slot state exactly. The stimulus applies one operation per cycle, so fills, root writes, flushes and lookups never overlap. It draws page numbers from a dozen values and contexts from four, so that overwrites of existing pages, global clashes and slot eviction all occur often.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;

   typedef enum logic [1:0] {
      ROOT_NONE  = 2'd0,
      ROOT_KEEP  = 2'd1,
      ROOT_FLUSH = 2'd2
   } root_act_e;

endpackage

// File: rtl/ctx_tlb_ctxreg.sv
module ctx_tlb_ctxreg
   import ctx_tlb_pkg::*;
#(
   parameter int ROOT_W = 32,
   parameter int CTX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              root_wr,
   input  logic [ROOT_W-1:0] root_data,
   output logic [CTX_W-1:0]  ctx_q,
   output root_act_e         act
);

   localparam int KEEP_BIT = ROOT_W - 1;

   always_comb begin
      if (!root_wr)
         act = ROOT_NONE;
      else if (root_data[KEEP_BIT])
         act = ROOT_KEEP;
      else
         act = ROOT_FLUSH;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctx_q <= '0;
      else if (root_wr)
         ctx_q <= root_data[CTX_W-1:0];
   end

   // R3
   ctx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      root_wr |=> ctx_q == $past(root_data[CTX_W-1:0]));

endmodule

// File: rtl/ctx_tlb_victim.sv
module ctx_tlb_victim #(
   parameter int ENTRIES = 16,
   parameter int IDX_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [IDX_W-1:0] ptr_q
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   generate
      if ((ENTRIES & (ENTRIES - 1)) == 0) begin : g_pow2
         always_ff @(posedge clk) begin
            if (!rst_n)
               ptr_q <= '0;
            else if (adv)
               ptr_q <= ptr_q + 1'b1;
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n)
               ptr_q <= '0;
            else if (adv)
               ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
         end
      end
   endgenerate

   // R10
   ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= LAST);

   // R10
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && ptr_q != LAST) |=> ptr_q == $past(ptr_q) + 1'b1);

endmodule

// File: rtl/ctx_tlb_cam.sv
module ctx_tlb_cam #(
   parameter int ENTRIES = 16,
   parameter int IDX_W   = 4,
   parameter int VPN_W   = 20,
   parameter int PFN_W   = 20,
   parameter int PERM_W  = 3,
   parameter int CTX_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTX_W-1:0]  cur_ctx,
   input  logic [VPN_W-1:0]  lk_vpn,
   output logic              lk_any,
   output logic [PFN_W-1:0]  lk_pfn,
   output logic [PERM_W-1:0] lk_perm,
   input  logic              fill_valid,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [PFN_W-1:0]  fill_pfn,
   input  logic [PERM_W-1:0] fill_perm,
   input  logic              fill_global,
   input  logic [IDX_W-1:0]  victim,
   output logic              victim_used,
   input  logic              flush_all,
   input  logic              flush_local
);

   logic [ENTRIES-1:0] valid_vec;
   logic [ENTRIES-1:0] glob_vec;
   logic [ENTRIES-1:0] hit_vec;
   logic [ENTRIES-1:0] conf_vec;
   logic [PFN_W-1:0]   pfn_arr  [ENTRIES];
   logic [PERM_W-1:0]  perm_arr [ENTRIES];
   logic               conf_any;
   logic [IDX_W-1:0]   conf_idx;
   logic [IDX_W-1:0]   wr_idx;

   always_comb begin
      conf_any = 1'b0;
      conf_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (conf_vec[i]) begin
            conf_any = 1'b1;
            conf_idx = IDX_W'(i);
         end
      end
   end

   assign wr_idx      = conf_any ? conf_idx : victim;
   assign victim_used = fill_valid && !conf_any;

   generate
      for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_slot
         logic              v_q;
         logic              g_q;
         logic [VPN_W-1:0]  tag_q;
         logic [CTX_W-1:0]  ctx_q;
         logic [PFN_W-1:0]  pfn_q;
         logic [PERM_W-1:0] perm_q;
         logic              we;
         logic              kill;

         assign we   = fill_valid && (wr_idx == IDX_W'(gi));
         assign kill = fill_valid && conf_vec[gi] && !we;

         assign hit_vec[gi]  = v_q && (tag_q == lk_vpn) &&
                               (g_q || (ctx_q == cur_ctx));
         assign conf_vec[gi] = v_q && (tag_q == fill_vpn) &&
                               (g_q || fill_global || (ctx_q == cur_ctx));

         assign valid_vec[gi] = v_q;
         assign glob_vec[gi]  = g_q;
         assign pfn_arr[gi]   = pfn_q;
         assign perm_arr[gi]  = perm_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               v_q    <= 1'b0;
               g_q    <= 1'b0;
               tag_q  <= '0;
               ctx_q  <= '0;
               pfn_q  <= '0;
               perm_q <= '0;
            end else begin
               if (flush_all || (flush_local && !g_q) || kill)
                  v_q <= 1'b0;
               if (we) begin
                  v_q    <= 1'b1;
                  g_q    <= fill_global;
                  tag_q  <= fill_vpn;
                  ctx_q  <= cur_ctx;
                  pfn_q  <= fill_pfn;
                  perm_q <= fill_perm;
               end
            end
         end
      end
   endgenerate

   always_comb begin
      lk_pfn  = '0;
      lk_perm = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (hit_vec[i]) begin
            lk_pfn  = lk_pfn | pfn_arr[i];
            lk_perm = lk_perm | perm_arr[i];
         end
      end
   end

   assign lk_any = |hit_vec;

   // R9
   single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   // R8
   flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_all && !fill_valid) |=> valid_vec == '0);

   // R6
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush_all && !flush_local && !fill_valid) |=> $stable(valid_vec));

   // R7
   global_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_local && !flush_all && !fill_valid) |=>
         (($past(valid_vec & glob_vec) & ~valid_vec) == '0));

   // R5
   local_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_local && !fill_valid) |=> ((valid_vec & ~glob_vec) == '0));

   // R9
   fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && !flush_all) |=> $countones(valid_vec) >= 1);

endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
   import ctx_tlb_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int PFN_W   = 20,
   parameter int PERM_W  = 3,
   parameter int CTX_W   = 4,
   parameter int ROOT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VPN_W-1:0]  lk_vpn,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [PFN_W-1:0]  rsp_pfn,
   output logic [PERM_W-1:0] rsp_perm,
   input  logic              fill_valid,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [PFN_W-1:0]  fill_pfn,
   input  logic [PERM_W-1:0] fill_perm,
   input  logic              fill_global,
   input  logic              root_wr,
   input  logic [ROOT_W-1:0] root_data,
   input  logic              flush_all
);

   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   generate
      if (ENTRIES < 2) begin : g_bad_entries
         $error("ctx_tlb: ENTRIES must be at least 2");
      end
      if (CTX_W < 1 || CTX_W >= ROOT_W) begin : g_bad_ctx
         $error("ctx_tlb: CTX_W must lie between 1 and ROOT_W-1");
      end
      if (VPN_W < 1 || PFN_W < 1 || PERM_W < 1) begin : g_bad_width
         $error("ctx_tlb: field widths must be positive");
      end
   endgenerate

   logic [CTX_W-1:0]  cur_ctx;
   root_act_e         root_act;
   logic [IDX_W-1:0]  victim;
   logic              victim_used;
   logic              lk_any;
   logic [PFN_W-1:0]  lk_pfn;
   logic [PERM_W-1:0] lk_perm;

   ctx_tlb_ctxreg #(
      .ROOT_W (ROOT_W),
      .CTX_W  (CTX_W)
   ) i_ctxreg (
      .clk       (clk),
      .rst_n     (rst_n),
      .root_wr   (root_wr),
      .root_data (root_data),
      .ctx_q     (cur_ctx),
      .act       (root_act)
   );

   ctx_tlb_victim #(
      .ENTRIES (ENTRIES),
      .IDX_W   (IDX_W)
   ) i_victim (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (victim_used),
      .ptr_q (victim)
   );

   ctx_tlb_cam #(
      .ENTRIES (ENTRIES),
      .IDX_W   (IDX_W),
      .VPN_W   (VPN_W),
      .PFN_W   (PFN_W),
      .PERM_W  (PERM_W),
      .CTX_W   (CTX_W)
   ) i_cam (
      .clk         (clk),
      .rst_n       (rst_n),
      .cur_ctx     (cur_ctx),
      .lk_vpn      (lk_vpn),
      .lk_any      (lk_any),
      .lk_pfn      (lk_pfn),
      .lk_perm     (lk_perm),
      .fill_valid  (fill_valid),
      .fill_vpn    (fill_vpn),
      .fill_pfn    (fill_pfn),
      .fill_perm   (fill_perm),
      .fill_global (fill_global),
      .victim      (victim),
      .victim_used (victim_used),
      .flush_all   (flush_all),
      .flush_local (root_act == ROOT_FLUSH)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_pfn   <= '0;
         rsp_perm  <= '0;
      end else begin
         rsp_valid <= lk_valid;
         rsp_hit   <= lk_valid && lk_any;
         rsp_pfn   <= (lk_valid && lk_any) ? lk_pfn : '0;
         rsp_perm  <= (lk_valid && lk_any) ? lk_perm : '0;
      end
   end

   // R1
   rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_valid);

   // R1
   rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> (!rsp_valid && !rsp_hit));

   // R2
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_hit |-> (rsp_pfn == '0 && rsp_perm == '0));

endmodule

// File: tb/test_ctx_tlb.sv
module test_ctx_tlb;

   localparam int CLK_PERIOD = 10;
   localparam int E      = 16;
   localparam int VPN_W  = 20;
   localparam int PFN_W  = 20;
   localparam int PERM_W = 3;
   localparam int CTX_W  = 4;
   localparam int ROOT_W = 32;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              lk_valid;
   logic [VPN_W-1:0]  lk_vpn;
   logic              rsp_valid, rsp_hit;
   logic [PFN_W-1:0]  rsp_pfn;
   logic [PERM_W-1:0] rsp_perm;
   logic              fill_valid, fill_global;
   logic [VPN_W-1:0]  fill_vpn;
   logic [PFN_W-1:0]  fill_pfn;
   logic [PERM_W-1:0] fill_perm;
   logic              root_wr;
   logic [ROOT_W-1:0] root_data;
   logic              flush_all;

   always #(CLK_PERIOD / 2) clk = ~clk;

   ctx_tlb #(
      .ENTRIES (E), .VPN_W (VPN_W), .PFN_W (PFN_W),
      .PERM_W (PERM_W), .CTX_W (CTX_W), .ROOT_W (ROOT_W)
   ) i_ctx_tlb (
      .clk (clk), .rst_n (rst_n),
      .lk_valid (lk_valid), .lk_vpn (lk_vpn),
      .rsp_valid (rsp_valid), .rsp_hit (rsp_hit),
      .rsp_pfn (rsp_pfn), .rsp_perm (rsp_perm),
      .fill_valid (fill_valid), .fill_vpn (fill_vpn),
      .fill_pfn (fill_pfn), .fill_perm (fill_perm),
      .fill_global (fill_global),
      .root_wr (root_wr), .root_data (root_data),
      .flush_all (flush_all)
   );

   // reference model
   bit                m_v    [E];
   bit                m_g    [E];
   logic [VPN_W-1:0]  m_tag  [E];
   logic [CTX_W-1:0]  m_ctx  [E];
   logic [PFN_W-1:0]  m_pfn  [E];
   logic [PERM_W-1:0] m_perm [E];
   int                m_ptr;
   logic [CTX_W-1:0]  m_cur;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   task automatic check_eq(string req, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < E; i++) begin
         m_v[i] = 0; m_g[i] = 0;
      end
      m_ptr = 0;
      m_cur = '0;
   endtask

   function automatic int model_find(logic [VPN_W-1:0] vpn);
      for (int i = 0; i < E; i++)
         if (m_v[i] && m_tag[i] == vpn && (m_g[i] || m_ctx[i] == m_cur))
            return i;
      return -1;
   endfunction

   task automatic idle();
      lk_valid = 0; lk_vpn = '0;
      fill_valid = 0; fill_vpn = '0; fill_pfn = '0; fill_perm = '0;
      fill_global = 0;
      root_wr = 0; root_data = '0;
      flush_all = 0;
   endtask

   task automatic op_fill(logic [VPN_W-1:0] vpn, logic [PFN_W-1:0] pfn,
                          logic [PERM_W-1:0] perm, bit g);
      int tgt = -1;
      fill_valid = 1; fill_vpn = vpn; fill_pfn = pfn;
      fill_perm = perm; fill_global = g;
      for (int i = 0; i < E; i++) begin
         if (m_v[i] && m_tag[i] == vpn && (m_g[i] || g || m_ctx[i] == m_cur)) begin
            if (tgt < 0) tgt = i;
            else m_v[i] = 0;
         end
      end
      if (tgt < 0) begin
         tgt = m_ptr;
         m_ptr = (m_ptr + 1) % E;
      end
      m_v[tgt] = 1; m_g[tgt] = g; m_tag[tgt] = vpn;
      m_ctx[tgt] = m_cur; m_pfn[tgt] = pfn; m_perm[tgt] = perm;
      @(negedge clk);
      idle();
   endtask

   task automatic op_root(logic [CTX_W-1:0] ctx, bit keep);
      root_wr = 1;
      root_data = '0;
      root_data[CTX_W-1:0] = ctx;
      root_data[ROOT_W-1] = keep;
      root_data[ROOT_W-2:12] = 20'h5A5A5;
      m_cur = ctx;
      if (!keep)
         for (int i = 0; i < E; i++)
            if (!m_g[i]) m_v[i] = 0;
      @(negedge clk);
      idle();
   endtask

   task automatic op_flush();
      flush_all = 1;
      for (int i = 0; i < E; i++) m_v[i] = 0;
      @(negedge clk);
      idle();
   endtask

   task automatic op_look(logic [VPN_W-1:0] vpn, string req);
      int k = model_find(vpn);
      lk_valid = 1; lk_vpn = vpn;
      @(negedge clk);
      idle();
      check_eq(req, "rsp_valid", rsp_valid, 1);
      check_eq(req, "rsp_hit", rsp_hit, (k >= 0) ? 1 : 0);
      check_eq(req, "rsp_pfn", rsp_pfn, (k >= 0) ? m_pfn[k] : 0);
      check_eq(req, "rsp_perm", rsp_perm, (k >= 0) ? m_perm[k] : 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd7331));
      idle();
      model_reset();
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 R11: idle response after reset, every page misses
      check_eq("R1", "rsp_valid idle", rsp_valid, 0);
      check_eq("R11", "rsp_hit idle", rsp_hit, 0);
      op_look(20'h00005, "R11");
      op_look(20'h00000, "R2");

      // R1: basic hit in context 0
      op_fill(20'h00100, 20'hABCDE, 3'd5, 0);
      op_look(20'h00100, "R1");
      check_eq("R1", "pfn direct", rsp_pfn, 20'hABCDE);

      // R3: other context misses, return with keep bit hits (R6)
      op_root(4'd3, 1);
      op_look(20'h00100, "R3");
      check_eq("R3", "hit other ctx", rsp_hit, 0);
      op_root(4'd0, 1);
      op_look(20'h00100, "R6");
      check_eq("R6", "hit kept", rsp_hit, 1);

      // R4 R5 R7: global survives flushing root write, local does not
      op_fill(20'h00200, 20'h12345, 3'd3, 1);
      op_root(4'd7, 0);
      op_look(20'h00200, "R4");
      check_eq("R7", "global kept", rsp_hit, 1);
      op_root(4'd0, 1);
      op_look(20'h00100, "R5");
      check_eq("R5", "local dropped", rsp_hit, 0);

      // R9: refill of same page overwrites
      op_fill(20'h00300, 20'h00011, 3'd1, 0);
      op_fill(20'h00300, 20'h00022, 3'd2, 0);
      op_look(20'h00300, "R9");
      check_eq("R9", "new pfn", rsp_pfn, 20'h00022);

      // R8: full flush drops the global entry too
      op_flush();
      op_look(20'h00200, "R8");
      check_eq("R8", "global flushed", rsp_hit, 0);

      // R10: fill E distinct pages, next new page evicts the first
      for (int i = 0; i < E; i++)
         op_fill(VPN_W'(32'h1000 + i), PFN_W'(32'h500 + i), 3'd7, 0);
      op_look(20'h01000, "R10");
      check_eq("R10", "full set first", rsp_hit, 1);
      op_fill(20'h02000, 20'h00999, 3'd4, 0);
      op_look(20'h01000, "R10");
      check_eq("R10", "first evicted", rsp_hit, 0);
      op_look(20'h01001, "R10");
      check_eq("R10", "second kept", rsp_hit, 1);

      // random mix against the model
      for (int n = 0; n < 1500; n++) begin
         int sel = $urandom_range(0, 99);
         logic [VPN_W-1:0] v = VPN_W'($urandom_range(0, 11));
         if (sel < 40)
            op_fill(v, PFN_W'($urandom), PERM_W'($urandom),
                    ($urandom_range(0, 7) == 0));
         else if (sel < 48)
            op_root(CTX_W'($urandom_range(0, 3)), $urandom_range(0, 1) == 1);
         else if (sel < 50)
            op_flush();
         else
            op_look(v, "R3");
      end

      finish_run();
   end

endmodule